// File: doc/BRIEF.md
# Fractional-N Feedback Divider with Third-Order Noise Shaping

This block divides a fast input clock (the output of a prescaler in a phase-locked loop feedback path) by a ratio that changes from one division cycle to the next. Over many cycles the average ratio is `INT + FRAC/MOD`. A cascade of three modulo-`MOD` accumulators picks a small signed correction for each cycle. The correction is added to the integer part to give that cycle's divide value. The divide value is never allowed below a floor of 31. The block emits one single-clock pulse each time a division cycle completes, and this pulse serves as the feedback edge for the phase detector.

The three setting inputs are captured into holding registers only on the terminal cycle of the counter. Each division cycle then uses the values captured at the previous terminal cycle. A change applied at any time therefore alters nothing in the current or the next period, and it governs the period after that. The modulator state is cleared whenever the captured fraction or modulus differs from the value held before, and also whenever the captured fraction is zero. A new setting therefore always starts from a clean accumulator state, and a zero fraction gives a plain integer divider.

Top module: `fracn_feedback_div`

## Requirements
- R1: While `rst` is high, `pulse_out` is 0. On the first clock edge with `rst` low, the counter is at its terminal count, so `pulse_out` is 1 in the cycle after that edge.
- R2: `pulse_out` is high for exactly one input clock per division cycle. The number of clocks between two consecutive rising pulses equals that cycle's divide value.
- R3: When the captured fraction is 0, every interval between pulses equals `INT` exactly, with no dithering.
- R4: When the fraction is non-zero and `INT` is at least 34, every interval lies within `INT-3` to `INT+4`. The modulator correction is always in the range -3 to +4.
- R5: Starting from a cleared modulator, the sum of `L` consecutive intervals lies within `L*INT + floor(L*FRAC/MOD) - 3` to `L*INT + floor(L*FRAC/MOD) + 4`.
- R6: When `FRAC` equals `MOD`, every interval equals `INT+1`.
- R7: No interval is ever shorter than 31 clocks, even when `INT` plus the correction is smaller.
- R8: Setting inputs are captured only at a terminal cycle. After a change made just after a pulse, the next two intervals keep the old value and the third interval uses the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider input clock |
| rst | input | 1 | Synchronous active-high reset |
| int_in | input | 9 | Integer part of the ratio (31 to 511) |
| frac_in | input | 12 | Fraction numerator (0 to MOD) |
| mod_in | input | 12 | Fraction modulus (2 to 4095) |
| pulse_out | output | 1 | One-clock pulse per completed division cycle |

## Verification
Two functions can land on the same terminal cycle: the capture of new settings, which may also clear the modulator, and the advance of the modulator that chooses the next divide value. When both occur together, the clear must win, and the advance must use the old held values. The bench provokes this by changing the settings on the very cycle a pulse is seen, and then on later cycles. Expected intervals are pushed into a scoreboard, from which the exact lag (old, old, new), the exact `INT+1` sequence and the clean `FRAC=0` sequence are judged.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int INT_W_DEF   = 9;
  localparam int MOD_W_DEF   = 12;
  localparam int MIN_DIV_DEF = 31;
  localparam int STAGES      = 3;
  localparam int CORR_W      = 4;
  typedef logic signed [CORR_W-1:0] corr_t;
endpackage

// File: rtl/mash_stage.sv
module mash_stage #(
  parameter int W = 12
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] addend,
  input  logic [W-1:0] modulus,
  output logic [W-1:0] sum_out,
  output logic         carry
);
  logic [W:0] s;
  always_comb begin
    s       = {1'b0, acc} + {1'b0, addend};
    carry   = (s >= {1'b0, modulus});
    sum_out = W'(carry ? (s - {1'b0, modulus}) : s);
  end
endmodule

// File: rtl/mash3_mod.sv
module mash3_mod
  import fracn_pkg::*;
#(
  parameter int W = MOD_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         clr,
  input  logic [W-1:0] frac,
  input  logic [W-1:0] modulus,
  output corr_t        corr
);
  logic [W-1:0] acc_q [STAGES];
  logic [W-1:0] nxt   [STAGES];
  logic [W-1:0] add   [STAGES+1];
  logic [STAGES-1:0] cy;
  logic c2_d1, c3_d1, c3_d2;

  assign add[0] = frac;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    mash_stage #(.W(W)) u_stage (
      .acc    (acc_q[i]),
      .addend (add[i]),
      .modulus(modulus),
      .sum_out(nxt[i]),
      .carry  (cy[i])
    );
    assign add[i+1] = nxt[i];
  end

  // noise-cancelling combination: c1 + (1-z^-1)c2 + (1-z^-1)^2 c3
  always_comb begin
    corr = 4'sd0;
    if (cy[0]) corr = corr + 4'sd1;
    if (cy[1]) corr = corr + 4'sd1;
    if (c2_d1) corr = corr - 4'sd1;
    if (cy[2]) corr = corr + 4'sd1;
    if (c3_d1) corr = corr - 4'sd2;
    if (c3_d2) corr = corr + 4'sd1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < STAGES; i++) acc_q[i] <= '0;
      c2_d1 <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else if (adv) begin
      for (int i = 0; i < STAGES; i++) acc_q[i] <= nxt[i];
      c2_d1 <= cy[1];
      c3_d1 <= cy[2];
      c3_d2 <= c3_d1;
    end
  end

  // R4: correction confined to -3..+4
  a_r4_corr_range: assert property (@(posedge clk) disable iff (rst)
    (corr >= -4'sd3) && (corr <= 4'sd4));
endmodule

// File: rtl/div_select.sv
module div_select
  import fracn_pkg::*;
#(
  parameter int INT_W   = INT_W_DEF,
  parameter int MIN_DIV = MIN_DIV_DEF,
  localparam int CNT_W  = INT_W + 1,
  localparam int RAW_W  = INT_W + 2
) (
  input  logic [INT_W-1:0] int_val,
  input  corr_t            corr,
  output logic [CNT_W-1:0] div_val
);
  logic signed [RAW_W-1:0] raw;
  always_comb begin
    raw = $signed({2'b00, int_val}) + $signed({{(RAW_W-CORR_W){corr[CORR_W-1]}}, corr});
    if (raw < RAW_W'(MIN_DIV)) div_val = CNT_W'(MIN_DIV);
    else                       div_val = CNT_W'(raw);
  end
endmodule

// File: rtl/div_counter.sv
module div_counter #(
  parameter int CNT_W   = 10,
  parameter int MIN_DIV = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] load_val,
  output logic             term,
  output logic             pulse_out
);
  logic [CNT_W-1:0] cnt;
  assign term = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      pulse_out <= 1'b0;
    end else begin
      pulse_out <= term;
      if (term) cnt <= load_val - 1'b1;
      else      cnt <= cnt - 1'b1;
    end
  end

  // R2: output pulse is a single clock wide
  a_r2_one_wide: assert property (@(posedge clk) disable iff (rst)
    pulse_out |=> !pulse_out);
  // R7: every reload honours the divide floor
  a_r7_floor: assert property (@(posedge clk) disable iff (rst)
    term |=> (cnt >= CNT_W'(MIN_DIV - 1)));
endmodule

// File: rtl/fracn_feedback_div.sv
module fracn_feedback_div
  import fracn_pkg::*;
#(
  parameter int INT_W   = INT_W_DEF,
  parameter int MOD_W   = MOD_W_DEF,
  parameter int MIN_DIV = MIN_DIV_DEF,
  localparam int CNT_W  = INT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INT_W-1:0] int_in,
  input  logic [MOD_W-1:0] frac_in,
  input  logic [MOD_W-1:0] mod_in,
  output logic             pulse_out
);
  logic [INT_W-1:0] int_q;
  logic [MOD_W-1:0] frac_q, mod_q;
  logic             term, clr;
  corr_t            corr;
  logic [CNT_W-1:0] div_val;

  // capture settings only at the terminal cycle
  always_ff @(posedge clk) begin
    if (rst || term) begin
      int_q  <= int_in;
      frac_q <= frac_in;
      mod_q  <= mod_in;
    end
  end

  assign clr = term && ((frac_in != frac_q) || (mod_in != mod_q) || (frac_in == '0));

  mash3_mod #(.W(MOD_W)) u_mod (
    .clk    (clk),
    .rst    (rst),
    .adv    (term),
    .clr    (clr),
    .frac   (frac_q),
    .modulus(mod_q),
    .corr   (corr)
  );

  div_select #(.INT_W(INT_W), .MIN_DIV(MIN_DIV)) u_sel (
    .int_val(int_q),
    .corr   (corr),
    .div_val(div_val)
  );

  div_counter #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_val (div_val),
    .term     (term),
    .pulse_out(pulse_out)
  );

  // R8: held settings move only at a terminal cycle
  a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
    !term |=> ($stable(int_q) && $stable(frac_q) && $stable(mod_q)));
  // R3: zero fraction yields zero correction
  a_r3_no_dither: assert property (@(posedge clk) disable iff (rst)
    (term && (frac_q == '0)) |-> (corr == 4'sd0));
endmodule

// File: tb/fracn_feedback_div_test.sv
module fracn_feedback_div_test;
  typedef struct {
    int    lo;
    int    hi;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  int_in = 9'd40;
  logic [11:0] frac_in = 12'd0;
  logic [11:0] mod_in = 12'd7;
  logic        pulse_out;

  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  int   last_pulse = -1;
  int   pulse_cnt = 0;
  int   seg_n = 0;
  int   seg_sum = 0;
  int   wide_seen = 0;
  logic prev_pulse = 1'b0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  fracn_feedback_div uut (
    .clk(clk), .rst(rst), .int_in(int_in), .frac_in(frac_in),
    .mod_in(mod_in), .pulse_out(pulse_out)
  );

  always #5 clk = ~clk;

  // monitor: measures intervals and pops expected items
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      last_pulse = -1;
      prev_pulse = 1'b0;
    end else begin
      if (pulse_out && prev_pulse) wide_seen++;
      if (pulse_out && !prev_pulse) begin
        if (last_pulse >= 0 && exp_q.size() > 0) begin
          exp_t e;
          int   iv;
          e  = exp_q.pop_front();
          iv = cyc - last_pulse;
          checks++;
          if (iv < e.lo || iv > e.hi) begin
            errors++;
            $display("FAIL %s: interval %0d expected %0d..%0d", e.tag, iv, e.lo, e.hi);
          end
          seg_sum += iv;
          seg_n++;
        end
        last_pulse = cyc;
        pulse_cnt++;
      end
      prev_pulse = pulse_out;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wait_pulses(input int n);
    int target;
    target = pulse_cnt + n;
    wait (pulse_cnt >= target);
  endtask

  // driver: apply settings, let them settle, push expected intervals
  task automatic run_seg(input int iv, input int fv, input int mv, input int n,
                         input int lo, input int hi, input string tag,
                         input int sum_lo, input int sum_hi, input string sum_tag);
    @(negedge clk);
    int_in  = 9'(iv);
    frac_in = 12'(fv);
    mod_in  = 12'(mv);
    wait_pulses(2);
    seg_n   = 0;
    seg_sum = 0;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.lo = lo; e.hi = hi; e.tag = tag;
      exp_q.push_back(e);
    end
    wait (seg_n == n);
    if (sum_lo >= 0) begin
      checks++;
      if (seg_sum < sum_lo || seg_sum > sum_hi) begin
        errors++;
        $display("FAIL %s: sum %0d expected %0d..%0d", sum_tag, seg_sum, sum_lo, sum_hi);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pulse_out == 1'b0, "R1 reset low", int'(pulse_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check(pulse_out == 1'b1, "R1 first pulse", int'(pulse_out), 1);
    @(negedge clk);
    check(pulse_out == 1'b0, "R2 pulse width", int'(pulse_out), 0);

    // R3: integer mode
    run_seg(40, 0, 7, 6, 40, 40, "R3 int40", -1, -1, "");
    run_seg(200, 0, 4095, 4, 200, 200, "R3 int200", -1, -1, "");

    // R8: change right after a pulse; old, old, new
    run_seg(100, 0, 9, 2, 100, 100, "R3 int100", -1, -1, "");
    wait_pulses(1);
    int_in = 9'd60;
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      e.lo  = (k < 2) ? 100 : 60;
      e.hi  = e.lo;
      e.tag = (k < 2) ? "R8 old held" : "R8 new used";
      exp_q.push_back(e);
    end
    seg_n = 0;
    wait (seg_n == 4);

    // R6: fraction equals modulus
    run_seg(50, 13, 13, 5, 51, 51, "R6 frac=mod", -1, -1, "");

    // R4 / R5: fractional modes
    run_seg(64, 1, 3, 30, 61, 68, "R4 f1/3", 30*64+10-3, 30*64+10+4, "R5 f1/3");
    run_seg(300, 2047, 4095, 40, 297, 304, "R4 f2047/4095",
            40*300+19-3, 40*300+19+4, "R5 f2047/4095");
    run_seg(511, 4000, 4001, 20, 508, 515, "R4 f4000/4001",
            20*511+19-3, 20*511+19+4, "R5 f4000/4001");

    // R7: floor at 31
    run_seg(31, 5, 11, 30, 31, 35, "R7 floor", -1, -1, "");

    // back to integer after fractional: no leftover dithering
    run_seg(77, 0, 11, 5, 77, 77, "R3 after frac", -1, -1, "");

    check(wide_seen == 0, "R2 single-clock pulses", wide_seen, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule